// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a per-processor countdown timer that sits inside a local interrupt controller. Software programs it through 32-bit word registers addressed by word index: a timer control entry (interrupt vector, suppress bit and repeat-mode bit), a prescaler selection, and a start value. Storing a start value loads the live counter and begins the countdown. The live counter steps down once for every prescaler tick.

When the countdown expires, the block emits a single-cycle request that carries the programmed 8-bit vector toward the interrupt delivery logic. In repeat mode the counter reloads the start value and runs again without further software action. In single-shot mode it parks at zero. Software can read the live count back at any time. Prioritisation and acknowledge handling belong to the surrounding controller.

Top module: `lvt_timer`

## Requirements
- R1: Word indices are 0xC8 for the control entry, 0xE0 for the start value, 0xE4 for the live count and 0xF8 for the prescaler selection. The control entry reads back bits 7:0 as the vector, bit 16 as the suppress bit and bit 17 as the repeat bit, with all other bits zero. The prescaler register reads back only bits 3, 1 and 0.
- R2: After synchronous reset, the control entry reads 0x00010000 (suppress set). The start value, the live count and the prescaler register all read 0, and no request is issued.
- R3: A write to the start value register loads the full 32-bit value into the live count on the same clock edge. For example, 10,000,000 reads back intact, less the ticks that have elapsed since the write.
- R4: The prescaler code is {bit3, bit1, bit0}. Codes 0 to 6 divide by 2, 4, 8, 16, 32, 64 and 128, and code 7 (the word 0xB) divides by 1. After a start-value write at edge E, the live count decrements at edges E+D, E+2D and so on.
- R5: A countdown that expires from 1 produces `irq_valid` high for exactly the cycle after that edge, with `irq_vector` equal to the programmed vector. The interval from start to request is N·D cycles.
- R6: In repeat mode (bit 17 set), expiry reloads the stored start value, so requests recur every N·D cycles.
- R7: In single-shot mode (bit 17 clear), the live count stays at 0 after expiry and no further request is issued.
- R8: With the suppress bit set, the live count keeps stepping but no request is issued.
- R9: Writing 0 to the start value register stops the timer: the live count reads 0 and no request follows.
- R10: Writes to the live count register are ignored, and counting continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, an 8-bit word index and a 7-bit prescaler. These values let a ten-million start value load without truncation, and they make every prescaler ratio from 1 to 128 reachable within a short run. Small random start values combined with every prescaler code reach the expiry-from-1 corner, back-to-back repeat reloads and the divide-by-1 case in which N=1 fires on every cycle.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;

    localparam int unsigned VEC_W = 8;

    // Word indices (byte offset / 4)
    localparam logic [7:0] WIDX_CTRL  = 8'hC8;
    localparam logic [7:0] WIDX_START = 8'hE0;
    localparam logic [7:0] WIDX_LIVE  = 8'hE4;
    localparam logic [7:0] WIDX_PRESC = 8'hF8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_START,
        SEL_LIVE,
        SEL_PRESC
    } reg_sel_e;

    typedef struct packed {
        logic             repeat_mode;
        logic             suppress;
        logic [VEC_W-1:0] vector;
    } ctrl_entry_t;

    typedef logic [2:0] presc_code_t;

    localparam ctrl_entry_t CTRL_RESET = '{repeat_mode: 1'b0, suppress: 1'b1, vector: '0};

    function automatic reg_sel_e decode_index(input logic [7:0] idx);
        case (idx)
            WIDX_CTRL:  return SEL_CTRL;
            WIDX_START: return SEL_START;
            WIDX_LIVE:  return SEL_LIVE;
            WIDX_PRESC: return SEL_PRESC;
            default:    return SEL_NONE;
        endcase
    endfunction

    // Ratio for a prescaler code: 7 -> 1, otherwise 2 << code
    function automatic logic [7:0] presc_ratio(input presc_code_t c);
        if (c == 3'b111) return 8'd1;
        return 8'd2 << c;
    endfunction

    function automatic presc_code_t word_to_code(input logic [31:0] w);
        return {w[3], w[1], w[0]};
    endfunction

    function automatic logic [31:0] code_to_word(input presc_code_t c);
        return {28'd0, c[2], 1'b0, c[1], c[0]};
    endfunction

    function automatic ctrl_entry_t word_to_ctrl(input logic [31:0] w);
        ctrl_entry_t e;
        e.repeat_mode = w[17];
        e.suppress    = w[16];
        e.vector      = w[VEC_W-1:0];
        return e;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_entry_t e);
        return {14'd0, e.repeat_mode, e.suppress, 8'd0, e.vector};
    endfunction

endpackage

// File: rtl/lvt_timer_regs.sv
module lvt_timer_regs
    import lvt_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_entry_t       ctrl,
    output presc_code_t       presc_code,
    output logic [CNT_W-1:0]  start_val,
    output logic              load,
    output logic [CNT_W-1:0]  load_val
);

    reg_sel_e    sel;
    ctrl_entry_t ctrl_q;
    presc_code_t code_q;
    logic [CNT_W-1:0] start_q;
    logic [31:0] wword;

    assign sel      = decode_index(8'(bus_addr));
    assign wword    = 32'(bus_wdata);
    assign load     = bus_wr && (sel == SEL_START);
    assign load_val = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RESET;
            code_q  <= '0;
            start_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_CTRL:  ctrl_q  <= word_to_ctrl(wword);
                SEL_PRESC: code_q  <= word_to_code(wword);
                SEL_START: start_q <= bus_wdata[CNT_W-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL:  bus_rdata = DATA_W'(ctrl_to_word(ctrl_q));
            SEL_PRESC: bus_rdata = DATA_W'(code_to_word(code_q));
            SEL_START: bus_rdata = DATA_W'(start_q);
            SEL_LIVE:  bus_rdata = DATA_W'(live_cnt);
            default:   bus_rdata = '0;
        endcase
    end

    assign ctrl       = ctrl_q;
    assign presc_code = code_q;
    assign start_val  = start_q;

    // R1: reserved bits of the control entry always read as zero
    a_r1_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL) |-> (bus_rdata[31:18] == '0 && bus_rdata[15:8] == '0));

endmodule

// File: rtl/lvt_timer_presc.sv
module lvt_timer_presc
    import lvt_timer_pkg::*;
#(
    parameter int unsigned PRE_W = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        run,
    input  presc_code_t code,
    output logic        tick
);

    localparam int unsigned CMP_W = (PRE_W + 1 > 8) ? PRE_W + 1 : 8;

    logic [PRE_W-1:0] pre_q;
    logic [7:0]       ratio;
    logic [CMP_W-1:0] limit;

    assign ratio = presc_ratio(code);
    assign limit = CMP_W'(ratio) - CMP_W'(1);
    assign tick  = run && !clear && (CMP_W'(pre_q) >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear || tick || !run) pre_q <= '0;
        else                              pre_q <= pre_q + 1'b1;
    end

    // R4: with a ratio above 1 two ticks are never adjacent
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && ratio > 8'd1) |=> (!tick || ratio == 8'd1));

    // R4: at ratio 1 a running counter ticks every cycle
    a_r4_div1_every_cycle: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && ratio == 8'd1) |-> tick);

endmodule

// File: rtl/lvt_timer_count.sv
module lvt_timer_count
    import lvt_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] start_val,
    input  logic             tick,
    input  ctrl_entry_t      ctrl,
    output logic [CNT_W-1:0] cnt,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);

    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    assign expire = !load && tick && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= expire && !ctrl.suppress;
            if (expire) irq_vector <= ctrl.vector;
            if (load) begin
                cnt_q <= load_val;
            end else if (tick && cnt_q != '0) begin
                if (expire) cnt_q <= ctrl.repeat_mode ? start_val : '0;
                else        cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt = cnt_q;

    // R5: a request follows only a count of 1
    a_r5_fire_from_one: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ($past(cnt_q) == CNT_W'(1)));

    // R8: no request while suppressed
    a_r8_suppressed: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !$past(ctrl.suppress));

    // R6: repeat mode reloads the stored start value at expiry
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && $past(ctrl.repeat_mode)) |-> (cnt_q == start_val));

    // R7 / R9: an idle counter stays at zero until loaded
    a_r7_park_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));

    // R10: without a tick or a load the count holds
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt_q));

    // R3: the live count never exceeds the stored start value
    a_r3_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= start_val);

endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
    import lvt_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PRE_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);

    ctrl_entry_t      ctrl;
    presc_code_t      presc_code;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] live_cnt;
    logic             load;
    logic             tick;
    logic             run;

    assign run = (live_cnt != '0);

    lvt_timer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .live_cnt   (live_cnt),
        .bus_rdata  (bus_rdata),
        .ctrl       (ctrl),
        .presc_code (presc_code),
        .start_val  (start_val),
        .load       (load),
        .load_val   (load_val)
    );

    lvt_timer_presc #(.PRE_W(PRE_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .run   (run),
        .code  (presc_code),
        .tick  (tick)
    );

    lvt_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (load_val),
        .start_val  (start_val),
        .tick       (tick),
        .ctrl       (ctrl),
        .cnt        (live_cnt),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    // R9: a zero load leaves nothing running
    a_r9_zero_stops: assert property (@(posedge clk) disable iff (rst)
        (load && load_val == '0) |=> (!run && !tick));

endmodule

// File: tb/tb_lvt_timer.sv
`timescale 1ns/1ps
module tb_lvt_timer;

    localparam logic [7:0] A_CTRL  = 8'hC8;
    localparam logic [7:0] A_START = 8'hE0;
    localparam logic [7:0] A_LIVE  = 8'hE4;
    localparam logic [7:0] A_PRESC = 8'hF8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = A_LIVE;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lvt_timer dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    function automatic int ratio_of(input int code);
        return (code == 7) ? 1 : (2 << code);
    endfunction

    function automatic logic [31:0] presc_word(input int code);
        return {28'd0, code[2], 1'b0, code[1], code[0]};
    endfunction

    function automatic logic [31:0] ctrl_word(input bit rep, input bit sup, input logic [7:0] v);
        return {14'd0, rep, sup, 8'd0, v};
    endfunction

    function automatic longint exp_count(input longint n, input int d, input int edges, input bit rep);
        longint t = edges / d;
        if (n == 0) return 0;
        if (rep) return n - (t % n);
        return (t >= n) ? 0 : n - t;
    endfunction

    function automatic int exp_pulses(input longint n, input int d, input int edges, input bit rep, input bit sup);
        longint t = edges / d;
        if (sup || n == 0) return 0;
        if (rep) return int'(t / n);
        return (t >= n) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_LIVE;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #0.1; d = bus_rdata; bus_addr = A_LIVE;
    endtask

    // Program, start, observe for `edges` cycles, check count and pulses
    task automatic run_case(input string tag, input longint n, input int code,
                            input bit rep, input bit sup, input logic [7:0] v, input int edges);
        int pulses = 0;
        int badvec = 0;
        logic [31:0] rd;
        bus_write(A_CTRL, ctrl_word(rep, sup, v));
        bus_write(A_PRESC, presc_word(code));
        bus_write(A_START, 32'(n));
        for (int i = 0; i < edges; i++) begin
            @(negedge clk);
            if (irq_valid) begin
                pulses++;
                if (irq_vector != v) badvec++;
            end
        end
        read_reg(A_LIVE, rd);
        chk({tag, " count"}, rd, exp_count(n, ratio_of(code), edges, rep));
        chk({tag, " pulses"}, pulses, exp_pulses(n, ratio_of(code), edges, rep, sup));
        chk({tag, " vector"}, badvec, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int dummy;
        dummy = $urandom(32'h5eed1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        read_reg(A_CTRL, rd);  chk("R2 ctrl reset", rd, 32'h0001_0000);
        read_reg(A_START, rd); chk("R2 start reset", rd, 0);
        read_reg(A_LIVE, rd);  chk("R2 live reset", rd, 0);
        read_reg(A_PRESC, rd); chk("R2 presc reset", rd, 0);
        chk("R2 no irq", irq_valid, 0);

        // R1: field readback
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        read_reg(A_CTRL, rd);  chk("R1 ctrl fields", rd, 32'h0003_00FF);
        bus_write(A_PRESC, 32'hFFFF_FFFF);
        read_reg(A_PRESC, rd); chk("R1 presc fields", rd, 32'h0000_000B);
        bus_write(A_CTRL, ctrl_word(1'b0, 1'b1, 8'h00));

        // R3: full-width load
        run_case("R3 big", 10000000, 7, 1'b1, 1'b0, 8'h20, 3);

        // R5 / R6: N=1 divide-by-1 repeat fires every cycle
        run_case("R6 n1", 1, 7, 1'b1, 1'b0, 8'h41, 10);
        // R6: repeat with divide 4
        run_case("R6 div4", 5, 1, 1'b1, 1'b0, 8'h42, 63);
        // R7: single-shot parks at zero
        run_case("R7 oneshot", 6, 0, 1'b0, 1'b0, 8'h55, 40);
        // R8: suppressed keeps counting, no request
        run_case("R8 suppress", 4, 7, 1'b1, 1'b1, 8'h66, 17);
        // R4: largest ratio
        run_case("R4 div128", 2, 6, 1'b1, 1'b0, 8'h77, 600);

        // R9: zero stops a running timer
        run_case("R9 prep", 3, 7, 1'b1, 1'b0, 8'h11, 1);
        run_case("R9 zero", 0, 7, 1'b1, 1'b0, 8'h11, 20);

        // R10: live-count write ignored
        bus_write(A_PRESC, presc_word(7));
        bus_write(A_CTRL, ctrl_word(1'b1, 1'b0, 8'h12));
        bus_write(A_START, 50);
        repeat (5) @(negedge clk);
        bus_write(A_LIVE, 32'd3);
        repeat (4) @(negedge clk);
        read_reg(A_LIVE, rd); chk("R10 ignored", rd, 40);

        // R4 / R5 / R6 / R7 / R8: random mix
        for (int k = 0; k < 24; k++) begin
            longint n = 1 + ($urandom % 12);
            int code = $urandom % 8;
            bit rep = $urandom % 2;
            bit sup = ($urandom % 4) == 0;
            logic [7:0] v = 8'($urandom);
            int e = int'(n) * ratio_of(code) * 2 + ($urandom % 5);
            run_case("R4 random", n, code, rep, sup, v, e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule